// File: doc/BRIEF.md
# Trilinear Texel Cache with Parity-Interleaved Banks

This block is a read-only texel cache that sits between a fragment texturing unit and texture memory. A request names a mipmap level `L` and two bilinear base coordinates: one on level `L` and one on level `L+1`. The cache returns all eight texels of that trilinear footprint together, one cycle after it accepts the request.

Storage is split into eight banks. A texel goes to a bank chosen by the parity of its two coordinates and by the parity of its level. The four texels of a 2x2 quad therefore always land in four different banks. The two levels of a trilinear lookup always land in opposite bank groups. Each bank has its own tags and makes its own hit or miss decision.

Each bank is two-way set-associative with least-recently-used replacement, so blocks from two different mip levels can share a set. One cache line is one square texel block of RGBA words, spread over the four banks of its group. On a miss the request is stalled and the misses are shown per bank. An external memory model then fills the missing quarter-lines through the fill port. The request is accepted once all eight lookups hit. With default parameters the cache holds 16 KB: 8 banks x 64 sets x 2 ways x four 32-bit texels.

Top module: `texcache_top`

## Requirements
- R1: A request is accepted on a rising edge where `req_valid` is high and `req_stall` is low. On the following cycle `resp_valid` is high for one cycle. `resp_texels` bits [32s+31:32s] hold slot s = {lv,dy,dx}, which is the texel at level `req_level+lv` and coordinate (bu+dx, bv+dy). The base (bu,bv) is (`req_u0`,`req_v0`) when lv=0 and (`req_u1`,`req_v1`) when lv=1.
- R2: A texel at level l and coordinate (u,v) lives in bank {l[0], v[0], u[0]}. Bit b of `miss_o` is high when the footprint texel held by bank b is absent, and `miss_o` is zero while `req_valid` is low.
- R3: While any lookup of a valid request misses, `req_stall` is high. On an empty cache all eight bits of `miss_o` are set.
- R4: When all eight lookups hit, `req_stall` is low and the request is accepted on the first edge.
- R5: A fill writes one quarter-line into bank `fill_bank`, for block (`fill_bx`,`fill_by`) of level `fill_level`. 32-bit word k of `fill_data` (bits [32k+31:32k]) is the texel at u = 4*bx + 2*(k mod 2) + b[0], v = 4*by + 2*(k div 2) + b[1], with 4x4 texel blocks.
- R6: Each bank has two ways per set. The set index is {by[2:0], bx[2:0]}, with block coordinates bx = u div 4 and by = v div 4. Two blocks with the same set index, for example the same block of two different levels, stay resident together.
- R7: A fill takes an invalid way when one exists. Otherwise it takes the way least recently used, where both a hit on an accepted request and a fill count as a use.
- R8: After reset `resp_valid` is low and every line is invalid.
- R9: No response is produced for a request while it is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Trilinear request present |
| req_level | input | LVL_W | Finer mip level L |
| req_u0 | input | CRD_W | Quad base u on level L |
| req_v0 | input | CRD_W | Quad base v on level L |
| req_u1 | input | CRD_W | Quad base u on level L+1 |
| req_v1 | input | CRD_W | Quad base v on level L+1 |
| req_stall | output | 1 | Request held: at least one bank missed |
| miss_o | output | 8 | Per-bank miss flags |
| fill_valid | input | 1 | Fill beat present |
| fill_bank | input | 3 | Target bank of the fill |
| fill_level | input | LVL_W | Mip level of the filled block |
| fill_bx | input | CRD_W-BLK_LOG | Block column of the filled block |
| fill_by | input | CRD_W-BLK_LOG | Block row of the filled block |
| fill_data | input | LINE_W | Quarter-line texel words |
| resp_valid | output | 1 | Eight texels valid |
| resp_texels | output | 8*TEX_W | Footprint texels in slot order |

## Verification
One pair of requests lets a quad straddle a block edge, so only the two banks holding the far column should miss. A design that keyed tags on the quad base instead of on each texel would report the wrong mask or return texels from the wrong block. Another sequence puts four mip levels onto one set. The two levels touched most recently must survive an eviction; a cache that replaced the most recent way, or always way 0, misses where a hit is expected. The checks compare every slot's texel against a value derived from the level and coordinates. That catches a swapped crossbar slot, a wrong word order within a quarter-line, and a level sent to the wrong bank group. A reset partway through the run must make a previously resident footprint miss in every bank.

// File: rtl/texcache_pkg.sv
package texcache_pkg;
  localparam int NBANK    = 8;   // 4 parity banks x 2 level groups
  localparam int BANK_SEL = 3;
  localparam int TEXEL_W  = 32;  // one RGBA word
  typedef logic [TEXEL_W-1:0] texel_t;
endpackage

// File: rtl/texcache_route.sv
// Steers each footprint texel to the bank that owns its parity.
module texcache_route
  import texcache_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int CRD_W = 12,
  localparam int HC_W = CRD_W - 1
) (
  input  logic [LVL_W-1:0]              req_level,
  input  logic [CRD_W-1:0]              u0,
  input  logic [CRD_W-1:0]              v0,
  input  logic [CRD_W-1:0]              u1,
  input  logic [CRD_W-1:0]              v1,
  output logic [NBANK-1:0][LVL_W-1:0]   bk_level,
  output logic [NBANK-1:0][HC_W-1:0]    bk_hu,
  output logic [NBANK-1:0][HC_W-1:0]    bk_hv
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic PU = 1'((b >> 0) & 1);
    localparam logic PV = 1'((b >> 1) & 1);
    localparam logic PG = 1'((b >> 2) & 1);
    logic             coarse;
    logic [CRD_W-1:0] bu, bv;
    always_comb begin
      coarse      = PG ^ req_level[0];
      bu          = coarse ? u1 : u0;
      bv          = coarse ? v1 : v0;
      bk_level[b] = req_level + LVL_W'(coarse);
      // parity-plane coordinate: the quad texel whose parity matches this bank
      bk_hu[b]    = bu[CRD_W-1:1] + HC_W'(bu[0] & ~PU);
      bk_hv[b]    = bv[CRD_W-1:1] + HC_W'(bv[0] & ~PV);
    end
  end
endmodule

// File: rtl/texcache_bank.sv
// One parity bank: two-way tags, per-set LRU bit, quarter-line data memory.
module texcache_bank
  import texcache_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int CRD_W   = 12,
  parameter int BLK_LOG = 2,
  parameter int SET_W   = 6,
  localparam int HC_W   = CRD_W - 1,
  localparam int BC_W   = CRD_W - BLK_LOG,
  localparam int WRD_W  = 2 * (BLK_LOG - 1),
  localparam int WPL    = 1 << WRD_W,
  localparam int LINE_W = WPL * TEXEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  lk_level,
  input  logic [HC_W-1:0]   lk_hu,
  input  logic [HC_W-1:0]   lk_hv,
  input  logic              lk_en,
  output logic              lk_miss,
  input  logic              fill_en,
  input  logic [LVL_W-1:0]  fill_level,
  input  logic [BC_W-1:0]   fill_bx,
  input  logic [BC_W-1:0]   fill_by,
  input  logic [LINE_W-1:0] fill_data,
  output texel_t            rd_texel
);
  localparam int SETS  = 1 << SET_W;
  localparam int SH    = SET_W / 2;
  localparam int TAG_W = LVL_W + 2 * (BC_W - SH);

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [SETS-1:0]  vld_q [2];
  logic [SETS-1:0]  lru_q;
  logic [LINE_W-1:0] mem [2*SETS];
  logic [LINE_W-1:0] line_q;
  logic [WRD_W-1:0]  word_q;

  // lookup side
  logic [BC_W-1:0]  bx, by;
  logic [SET_W-1:0] set;
  logic [TAG_W-1:0] tag;
  logic [WRD_W-1:0] word;
  logic [1:0]       match;
  logic             hway;

  always_comb begin
    bx   = lk_hu[HC_W-1:BLK_LOG-1];
    by   = lk_hv[HC_W-1:BLK_LOG-1];
    set  = {by[SH-1:0], bx[SH-1:0]};
    tag  = {lk_level, by[BC_W-1:SH], bx[BC_W-1:SH]};
    word = {lk_hv[BLK_LOG-2:0], lk_hu[BLK_LOG-2:0]};
    for (int w = 0; w < 2; w++)
      match[w] = vld_q[w][set] && (tag_q[w][set] == tag);
    hway    = match[1];
    lk_miss = ~|match;
  end

  // fill side
  logic [SET_W-1:0] fset;
  logic [TAG_W-1:0] ftag;
  logic             fway;

  always_comb begin
    fset = {fill_by[SH-1:0], fill_bx[SH-1:0]};
    ftag = {fill_level, fill_by[BC_W-1:SH], fill_bx[BC_W-1:SH]};
    if (!vld_q[0][fset])      fway = 1'b0;
    else if (!vld_q[1][fset]) fway = 1'b1;
    else                      fway = lru_q[fset];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q[0] <= '0;
      vld_q[1] <= '0;
      lru_q    <= '0;
    end else begin
      if (lk_en) lru_q[set] <= ~hway;
      if (fill_en) begin
        vld_q[fway][fset] <= 1'b1;
        lru_q[fset]       <= ~fway;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fway][fset] <= ftag;
  end

  // data memory: one write port (fill), one registered read port (lookup)
  always_ff @(posedge clk) begin
    if (fill_en) mem[{fway, fset}] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (lk_en) begin
      line_q <= mem[{hway, set}];
      word_q <= word;
    end
  end

  assign rd_texel = line_q[TEXEL_W*int'(word_q) +: TEXEL_W];

  // R6: a block is never resident in both ways of a set
  a_r6_single_way_hit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R5: the way written by a fill is valid afterwards
  a_r5_fill_marks_valid: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> vld_q[$past(fway)][$past(fset)]);

  // R7: a used way is no longer the LRU choice of its set
  a_r7_lru_moves_away: assert property (@(posedge clk) disable iff (rst)
    (lk_en && !(fill_en && fset == set)) |=> (lru_q[$past(set)] != $past(hway)));
endmodule

// File: rtl/texcache_gather.sv
// Output crossbar: puts the eight bank words back into footprint slot order.
module texcache_gather
  import texcache_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap_en,
  input  logic                   lev0,
  input  logic [1:0]             ubit,   // {u1[0], u0[0]}
  input  logic [1:0]             vbit,   // {v1[0], v0[0]}
  input  texel_t [NBANK-1:0]     bank_texel,
  output texel_t [NBANK-1:0]     slot_texel
);
  logic       lev0_q;
  logic [1:0] ubit_q, vbit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lev0_q <= 1'b0;
      ubit_q <= '0;
      vbit_q <= '0;
    end else if (cap_en) begin
      lev0_q <= lev0;
      ubit_q <= ubit;
      vbit_q <= vbit;
    end
  end

  for (genvar s = 0; s < NBANK; s++) begin : g_slot
    localparam int  LS = s / 4;
    localparam logic DY = 1'((s >> 1) & 1);
    localparam logic DX = 1'(s & 1);
    logic [BANK_SEL-1:0] src;
    always_comb begin
      src           = {lev0_q ^ 1'(LS), vbit_q[LS] ^ DY, ubit_q[LS] ^ DX};
      slot_texel[s] = bank_texel[src];
    end
  end
endmodule

// File: rtl/texcache_top.sv
module texcache_top
  import texcache_pkg::*;
#(
  parameter int LVL_W   = 4,
  parameter int CRD_W   = 12,
  parameter int BLK_LOG = 2,
  parameter int SET_W   = 6,
  parameter int TEX_W   = TEXEL_W,
  localparam int BC_W   = CRD_W - BLK_LOG,
  localparam int LINE_W = (1 << (2 * (BLK_LOG - 1))) * TEX_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [LVL_W-1:0]       req_level,
  input  logic [CRD_W-1:0]       req_u0,
  input  logic [CRD_W-1:0]       req_v0,
  input  logic [CRD_W-1:0]       req_u1,
  input  logic [CRD_W-1:0]       req_v1,
  output logic                   req_stall,
  output logic [7:0]             miss_o,
  input  logic                   fill_valid,
  input  logic [2:0]             fill_bank,
  input  logic [LVL_W-1:0]       fill_level,
  input  logic [BC_W-1:0]        fill_bx,
  input  logic [BC_W-1:0]        fill_by,
  input  logic [LINE_W-1:0]      fill_data,
  output logic                   resp_valid,
  output logic [8*TEX_W-1:0]     resp_texels
);
  localparam int HC_W = CRD_W - 1;

  logic [NBANK-1:0][LVL_W-1:0] bk_level;
  logic [NBANK-1:0][HC_W-1:0]  bk_hu, bk_hv;
  logic [NBANK-1:0]            bk_miss;
  texel_t [NBANK-1:0]          bk_texel;
  texel_t [NBANK-1:0]          slot_texel;
  logic                        accept;

  texcache_route #(.LVL_W(LVL_W), .CRD_W(CRD_W)) u_route (
    .req_level (req_level),
    .u0        (req_u0),
    .v0        (req_v0),
    .u1        (req_u1),
    .v1        (req_v1),
    .bk_level  (bk_level),
    .bk_hu     (bk_hu),
    .bk_hv     (bk_hv)
  );

  assign accept    = req_valid && !(|bk_miss);
  assign req_stall = req_valid && (|bk_miss);
  assign miss_o    = req_valid ? bk_miss : '0;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    texcache_bank #(
      .LVL_W(LVL_W), .CRD_W(CRD_W), .BLK_LOG(BLK_LOG), .SET_W(SET_W)
    ) u_bank (
      .clk        (clk),
      .rst        (rst),
      .lk_level   (bk_level[b]),
      .lk_hu      (bk_hu[b]),
      .lk_hv      (bk_hv[b]),
      .lk_en      (accept),
      .lk_miss    (bk_miss[b]),
      .fill_en    (fill_valid && (fill_bank == 3'(b))),
      .fill_level (fill_level),
      .fill_bx    (fill_bx),
      .fill_by    (fill_by),
      .fill_data  (fill_data),
      .rd_texel   (bk_texel[b])
    );
  end

  texcache_gather u_gather (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (accept),
    .lev0       (req_level[0]),
    .ubit       ({req_u1[0], req_u0[0]}),
    .vbit       ({req_v1[0], req_v0[0]}),
    .bank_texel (bk_texel),
    .slot_texel (slot_texel)
  );

  always_ff @(posedge clk) begin
    if (rst) resp_valid <= 1'b0;
    else     resp_valid <= accept;
  end

  assign resp_texels = slot_texel;

  // R9: a stalled request yields no response next cycle
  a_r9_no_resp_when_stalled: assert property (@(posedge clk) disable iff (rst)
    req_stall |=> !resp_valid);

  // R1: an accepted request is answered on the next cycle
  a_r1_resp_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_stall) |=> resp_valid);
endmodule

// File: tb/tb_texcache_top.sv
`timescale 1ns/1ps
module tb_texcache_top;
  localparam int LVL_W = 4, CRD_W = 12, BLK_LOG = 2, BC_W = CRD_W - BLK_LOG;
  localparam int LINE_W = 128;
  localparam int NV = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0; logic [LVL_W-1:0] req_level = 0;
  logic [CRD_W-1:0] req_u0 = 0, req_v0 = 0, req_u1 = 0, req_v1 = 0;
  logic req_stall; logic [7:0] miss_o;
  logic fill_valid = 0; logic [2:0] fill_bank = 0; logic [LVL_W-1:0] fill_level = 0;
  logic [BC_W-1:0] fill_bx = 0, fill_by = 0; logic [LINE_W-1:0] fill_data = 0;
  logic resp_valid; logic [255:0] resp_texels;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  texcache_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .req_u0(req_u0), .req_v0(req_v0), .req_u1(req_u1), .req_v1(req_v1),
    .req_stall(req_stall), .miss_o(miss_o), .fill_valid(fill_valid),
    .fill_bank(fill_bank), .fill_level(fill_level), .fill_bx(fill_bx),
    .fill_by(fill_by), .fill_data(fill_data), .resp_valid(resp_valid),
    .resp_texels(resp_texels));

  // {level, u0, v0, u1, v1, expected miss mask}
  localparam logic [59:0] VEC [NV] = '{
    {4'd0, 12'd0, 12'd0, 12'd0, 12'd0, 8'hFF},  // cold
    {4'd0, 12'd0, 12'd0, 12'd0, 12'd0, 8'h00},  // repeat
    {4'd0, 12'd2, 12'd2, 12'd1, 12'd1, 8'h00},  // same blocks
    {4'd0, 12'd3, 12'd0, 12'd0, 12'd0, 8'h05},  // straddles block column
    {4'd1, 12'd0, 12'd0, 12'd0, 12'd0, 8'h0F},  // level 2 shares set 0
    {4'd2, 12'd0, 12'd0, 12'd0, 12'd0, 8'hF0},  // level 3 shares set 0
    {4'd0, 12'd0, 12'd0, 12'd0, 12'd0, 8'h00},  // touch levels 0/1
    {4'd4, 12'd0, 12'd0, 12'd0, 12'd0, 8'hFF},  // evicts levels 2/3
    {4'd0, 12'd0, 12'd0, 12'd0, 12'd0, 8'h00},  // levels 0/1 kept
    {4'd2, 12'd0, 12'd0, 12'd0, 12'd0, 8'hFF},  // levels 2/3 were evicted
    {4'd0, 12'd4, 12'd4, 12'd2, 12'd2, 8'h0F},  // new set on level 0
    {4'd1, 12'd5, 12'd5, 12'd2, 12'd2, 8'hF0}   // new set on level 1
  };

  function automatic logic [31:0] tex(input logic [3:0] l, input logic [11:0] u, input logic [11:0] v);
    return {4'hA, l, v, u};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [3:0] l, input logic [11:0] u0, input logic [11:0] v0,
                         input logic [11:0] u1, input logic [11:0] v1, input logic [7:0] exp_mask);
    @(negedge clk);
    req_valid = 1; req_level = l; req_u0 = u0; req_v0 = v0; req_u1 = u1; req_v1 = v1;
    #1;
    check(miss_o == exp_mask, "R2 R3 R6 R7 miss mask", 64'(miss_o), 64'(exp_mask));
    if (exp_mask == 0) check(req_stall == 0, "R4 hit no stall", 64'(req_stall), 64'd0);
    else               check(req_stall == 1, "R3 stall on miss", 64'(req_stall), 64'd1);
    while (miss_o != 0) begin
      int b = 0;
      for (int i = 7; i >= 0; i--) if (miss_o[i]) b = i;
      begin
        logic ls = 1'(b >> 2) ^ l[0];
        logic [11:0] bu = ls ? u1 : u0;
        logic [11:0] bv = ls ? v1 : v0;
        logic [11:0] tu = bu + 12'(bu[0] ^ b[0]);
        logic [11:0] tv = bv + 12'(bv[0] ^ b[1]);
        logic [3:0] fl = l + 4'(ls);
        fill_valid = 1; fill_bank = 3'(b); fill_level = fl;
        fill_bx = tu[11:2]; fill_by = tv[11:2];
        for (int k = 0; k < 4; k++)
          fill_data[32*k +: 32] = tex(fl, {tu[11:2], 1'(k & 1), 1'(b & 1)},
                                      {tv[11:2], 1'((k >> 1) & 1), 1'((b >> 1) & 1)});
      end
      check(resp_valid == 0, "R9 no response while stalled", 64'(resp_valid), 64'd0);
      @(negedge clk);
      fill_valid = 0;
      #1;
    end
    @(negedge clk);
    req_valid = 0;
    check(resp_valid == 1, "R1 response valid", 64'(resp_valid), 64'd1);
    for (int s = 0; s < 8; s++) begin
      logic ls = 1'(s >> 2);
      logic [11:0] eu = (ls ? u1 : u0) + 12'(s & 1);
      logic [11:0] ev = (ls ? v1 : v0) + 12'((s >> 1) & 1);
      logic [31:0] e = tex(l + 4'(ls), eu, ev);
      check(resp_texels[32*s +: 32] == e, "R1 R5 texel slot", 64'(resp_texels[32*s +: 32]), 64'(e));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check(resp_valid == 0, "R8 reset resp_valid", 64'(resp_valid), 64'd0);
    check(miss_o == 0 && req_stall == 0, "R2 idle miss/stall", 64'(miss_o), 64'd0);
    for (int i = 0; i < NV; i++)
      run_req(VEC[i][59:56], VEC[i][55:44], VEC[i][43:32], VEC[i][31:20], VEC[i][19:8], VEC[i][7:0]);
    // R8: reset invalidates every line
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    #1;
    check(resp_valid == 0, "R8 resp_valid in reset", 64'(resp_valid), 64'd0);
    rst = 0;
    run_req(4'd0, 12'd0, 12'd0, 12'd0, 12'd0, 8'hFF);
    // idle after response
    @(negedge clk); #1;
    check(resp_valid == 0, "R1 single-cycle response", 64'(resp_valid), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule